// File: doc/BRIEF.md
# One-Wire Bit-Timing Prescaler

This block turns a system clock anywhere between 1 and 128 MHz into a roughly 1 MHz strobe. The one-wire slot sequencer uses that strobe as its microsecond time base. Software sets the rate by writing a single 8-bit configuration byte. The top bit of the byte switches the prescaler on. The low five bits hold two sub-fields whose factors multiply to give the total division.

The division is made in two cascaded stages. The first stage divides by an odd factor of 1, 3, 5 or 7. The second stage counts wraps of the first stage and divides by a power of two, from 1 up to 128. Their product covers the common crystal frequencies: 1, 3, 5 and 7 MHz need only the odd stage, binary rates need only the second stage, and rates such as 6, 12 or 56 MHz use both. Each write to the byte restarts both stages, so the period after a write is always a complete one.

Top module: `ow_prescale`

## Requirements
- R1: After reset the prescaler is disabled and `tick` stays low until a byte with bit 7 set is written.
- R2: While the byte in effect has bit 7 clear, `tick` is held low.
- R3: Bits 1:0 (value f) select an odd factor of 2f+1, giving 1, 3, 5 or 7.
- R4: Bits 4:2 (value n) select a power-of-two factor of 2^n, giving 1 up to 128.
- R5: When enabled, `tick` is high for exactly one clock cycle in every P = (2f+1)·2^n cycles. When P is 1, `tick` stays high continuously.
- R6: A write (`cfg_wr` high at a clock edge) restarts the division. `tick` is low in the cycle after the write edge, and the first tick is registered on the P-th edge after it.
- R7: Bits 6:5 of the written byte have no effect on timing.
- R8: The largest setting, f=3 and n=7, gives a period of 896 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_data | input | 8 | Configuration byte: bit 7 enable, bits 4:2 power-of-two select, bits 1:0 odd select |
| tick | output | 1 | Timing strobe, one cycle wide per period |

## Verification
The hardest case to reach is a rewrite that lands in the middle of a long period. The old counters are then part-way through both stages, and the new period has to start from zero rather than inherit that partial count. The stimulus enables the slowest binary setting, lets it run for some tens of cycles and then writes a short odd-only setting, which must give its first tick exactly seven cycles later. A reference model in the bench, built on integer phase counting, follows every write and is compared with `tick` on every clock. This exposes any tick that is stretched, early or missing across all the settings tried.

// File: rtl/ow_prescale_pkg.sv
package ow_prescale_pkg;
  parameter int CFG_W     = 8;
  parameter int ODD_SEL_W = 2;
  parameter int POW_SEL_W = 3;

  localparam int EN_BIT      = CFG_W - 1;
  localparam int ODD_MAX     = 2 * (2 ** ODD_SEL_W) - 1;
  localparam int ODD_CNT_W   = $clog2(ODD_MAX);
  localparam int POW_MAX_EXP = 2 ** POW_SEL_W - 1;
  localparam int POW_CNT_W   = POW_MAX_EXP;

  typedef struct packed {
    logic                 en;
    logic [POW_SEL_W-1:0] pow_sel;
    logic [ODD_SEL_W-1:0] odd_sel;
  } ps_cfg_t;

  // last count value of the odd stage: factor 2f+1, so terminal value is 2f
  function automatic logic [ODD_CNT_W-1:0] odd_last(input logic [ODD_SEL_W-1:0] sel);
    return ODD_CNT_W'({sel, 1'b0});
  endfunction

  // last count value of the binary stage: factor 2^n, terminal value 2^n - 1
  function automatic logic [POW_CNT_W-1:0] pow_last(input logic [POW_SEL_W-1:0] sel);
    return POW_CNT_W'((32'd1 << sel) - 32'd1);
  endfunction

  function automatic ps_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    ps_cfg_t c;
    c.en      = raw[EN_BIT];
    c.pow_sel = raw[ODD_SEL_W +: POW_SEL_W];
    c.odd_sel = raw[0 +: ODD_SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/ow_ps_cfg.sv
module ow_ps_cfg
  import ow_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] data,
  output ps_cfg_t          cfg,
  output logic             restart
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (wr) cfg <= decode_cfg(data);
  end

  assign restart = wr;
endmodule

// File: rtl/ow_ps_odd_div.sv
module ow_ps_odd_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;

  assign wrap = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (wrap)           cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ow_ps_pow_div.sv
module ow_ps_pow_div #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] last,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && step && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clear || !run) cnt <= '0;
    else if (done)          cnt <= '0;
    else if (step)          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ow_prescale.sv
module ow_prescale
  import ow_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             tick
);
  ps_cfg_t cfg;
  logic    restart;
  logic    odd_wrap;
  logic    period_end;
  logic    tick_q;

  ow_ps_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .data    (cfg_data),
    .cfg     (cfg),
    .restart (restart)
  );

  ow_ps_odd_div #(.CNT_W(ODD_CNT_W)) u_odd (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .run   (cfg.en),
    .last  (odd_last(cfg.odd_sel)),
    .wrap  (odd_wrap)
  );

  ow_ps_pow_div #(.CNT_W(POW_CNT_W)) u_pow (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .run   (cfg.en),
    .step  (odd_wrap),
    .last  (pow_last(cfg.pow_sel)),
    .done  (period_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       tick_q <= 1'b0;
    else if (restart) tick_q <= 1'b0;
    else              tick_q <= period_end;
  end

  assign tick = tick_q;
endmodule

// File: rtl/ow_prescale_chk.sv
module ow_prescale_chk
  import ow_prescale_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_data,
  input logic             tick,
  input logic             odd_wrap,
  input logic             period_end
);
  ps_cfg_t     sh_cfg;
  logic [11:0] sh_ratio;
  logic [11:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cfg   <= '0;
      sh_ratio <= 12'd1;
    end else if (cfg_wr) begin
      sh_cfg   <= decode_cfg(cfg_data);
      sh_ratio <= 12'((12'd2 * 12'(cfg_data[1:0]) + 12'd1) << cfg_data[4:2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gap <= '0;
    else if (cfg_wr)         gap <= '0;
    else if (tick)           gap <= 12'd1;
    else if (gap != 12'hFFF) gap <= gap + 12'd1;
  end

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_cfg.en |-> !tick);

  // R6
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tick);

  // R5
  period_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_cfg.en |-> (tick == (gap == sh_ratio)));

  // R5
  end_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> odd_wrap);
endmodule

bind ow_prescale ow_prescale_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_data   (cfg_data),
  .tick       (tick),
  .odd_wrap   (odd_wrap),
  .period_end (period_end)
);

// File: tb/ow_prescale_test.sv
module ow_prescale_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  int m_ratio = 1;
  int m_phase = 0;
  bit m_en = 0;
  bit m_tick = 0;

  ow_prescale uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .tick     (tick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_phase = 0; m_tick = 0; m_ratio = 1;
    end else if (cfg_wr) begin
      m_en    = cfg_data[7];
      m_ratio = (2 * int'(cfg_data[1:0]) + 1) * (1 << cfg_data[4:2]);
      m_phase = 0;
      m_tick  = 0;
    end else if (m_en) begin
      m_tick  = (m_phase == m_ratio - 1);
      m_phase = (m_phase + 1) % m_ratio;
    end else begin
      m_tick = 0;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // R5: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) check("R5 model", int'(tick), int'(m_tick));
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R6 low after write", int'(tick), 0);
  endtask

  task automatic cycles_to_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 5000);
  endtask

  task automatic measure(input logic [7:0] v, input string tag);
    int exp;
    int n;
    exp = (2 * int'(v[1:0]) + 1) * (1 << v[4:2]);
    write_cfg(v);
    cycles_to_tick(n);
    check({tag, " first"}, n, exp);
    cycles_to_tick(n);
    check({tag, " interval"}, n, exp);
  endtask

  task automatic quiet(input int len, input string tag);
    int hits = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tick) hits++;
    end
    check(tag, hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(tick), 0);
    rst_n = 1'b1;
    quiet(40, "R1 idle after reset");

    measure(8'h80, "R5 continuous");
    measure(8'h81, "R3 odd3");
    measure(8'h82, "R3 odd5");
    measure(8'h83, "R3 odd7");
    measure(8'h84, "R4 pow2");
    measure(8'h88, "R4 pow4");
    measure(8'h90, "R4 pow16");
    measure(8'h98, "R4 pow64");
    measure(8'h85, "R5 six");
    measure(8'h89, "R5 twelve");
    measure(8'h9C, "R5 onetwentyeight");
    measure(8'h9F, "R8 max");
    measure(8'hE1, "R7 spare bits");
    measure(8'hC6, "R7 spare bits");

    // mid-period rewrite
    write_cfg(8'h9C);
    repeat (50) @(negedge clk);
    measure(8'h83, "R6 rewrite");

    write_cfg(8'h05);
    quiet(2000, "R2 disabled");
    write_cfg(8'h00);
    quiet(100, "R2 disabled zero");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule